// File: doc/BRIEF.md
# Serial-Loaded Latched Switch Controller

This block is the digital control front end of an eight-switch array. A host writes a word over a three-wire serial port: a serial clock, a data line and an active-low select. While the select is low, data bits enter a shift register, most significant bit first. When the select rises, the whole register is copied into an output latch. Each latch bit enables one switch.

The register's most significant bit is echoed on a serial output, so several controllers can be chained on one select line. The port pins are asynchronous to the block. A free-running system clock oversamples them through synchronizers, and all edges are detected in that clock domain. The system clock must run at least four times faster than the serial clock.

An active-low reset clears the shift register, the latch and the echo output at once. Its release is synchronized to the system clock. The power-up state is all switches open.

Top module: `swctl_serial_top`

## Requirements
- R1: Asserting `rst_n` low clears `sw_en_o` and `dout_o` to zero at once, without waiting for a clock edge, and they stay zero while reset is held.
- R2: While `cs_n_i` is low, each rising edge of `sclk_i` shifts `din_i` into bit 0 of the shift register, and the register moves toward its MSB, so the first bit sent ends in bit 7. Bit n of `sw_en_o` drives switch n, with 1 meaning closed.
- R3: On each rising edge of `cs_n_i`, `sw_en_o` takes the shift register contents, one system clock after the synchronized edge is detected. `sw_en_o` never changes at any other time except reset.
- R4: While bits are being shifted in, `sw_en_o` keeps the word from the previous load.
- R5: `dout_o` shows the register MSB and updates only on falling edges of `sclk_i` while `cs_n_i` is low, so it repeats `din_i` eight serial clocks later.
- R6: A frame of more or fewer than eight serial clocks keeps and loads only the most recent eight bits, and older bits are shifted out.
- R7: While `cs_n_i` is high, activity on `sclk_i` and `din_i` changes neither the shift register nor `dout_o`. `dout_o` keeps the first bit of the last full frame.
- R8: The load on a rising edge of `cs_n_i` happens whether `sclk_i` is high or low at that moment.
- R9: Reset also clears the shift register. A frame with no serial clocks sent after reset loads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that oversamples the pins |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| sclk_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low frame select; its rising edge loads the latch |
| din_i | input | 1 | Serial data in, MSB first |
| dout_o | output | 1 | Serial echo of the register MSB, for chaining |
| sw_en_o | output | 8 | Latched switch enables, bit n for switch n |

## Verification
The bench checks frames that are too long or too short. A design that counted bits or cleared the register at frame start would load the wrong word. It raises the select while the serial clock is high, which a design that waited for a low clock would miss. It toggles the serial pins while the select is high, which catches a shifter not gated by select: the effect shows up both in the echo and in the next load of an empty frame. It also asserts reset after a frame of all ones, then loads an empty frame. A design that cleared only the latch would bring the stale ones back.

// File: rtl/swctl_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the serial switch controller.
// Assumes nothing beyond being compiled first.
package swctl_pkg;

    // Bundle of the three serial port pins as seen by the synchronizer
    typedef struct packed {
        logic din;
        logic cs_n;
        logic sclk;
    } pins_t;

    localparam int unsigned PIN_W = $bits(pins_t);

    // Idle levels while in reset: clock low, select high, data low
    localparam pins_t PIN_IDLE = '{din: 1'b0, cs_n: 1'b1, sclk: 1'b0};

endpackage

// File: rtl/swctl_rst_sync.sv
`timescale 1ns/1ps
// Reset synchronizer: assertion passes straight through (asynchronous),
// release is delayed by STAGES system clocks. Assumes STAGES >= 2.
module swctl_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n_i,
    output logic rst_n_o
);

    logic [STAGES-1:0] chain_q;

    // Shift ones in after release; clear at once on assertion
    always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/swctl_pin_sync.sv
`timescale 1ns/1ps
// Pin synchronizer and edge detector: brings WIDTH asynchronous pins into
// the clk domain through STAGES flops, then flags rising and falling edges
// one bit per pin. Assumes the pins hold each level for at least two
// clk periods, and that STAGES >= 2.
module swctl_pin_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;
    logic [WIDTH-1:0]             prev_q;

    // Synchronizer chain plus one extra flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], pin_i};
            prev_q  <= stage_q[STAGES-1];
        end
    end

    assign lvl_o = stage_q[STAGES-1];

    // Per-pin edge flags
    for (genvar b = 0; b < WIDTH; b++) begin : g_edge
        assign rise_o[b] =  lvl_o[b] & ~prev_q[b];
        assign fall_o[b] = ~lvl_o[b] &  prev_q[b];
    end

endmodule

// File: rtl/swctl_shift_latch.sv
`timescale 1ns/1ps
// Shift register, echo flop and output latch. Works on synchronized edge
// flags. It shifts on clock rise while the select is low, echoes the MSB on
// clock fall while the select is low, and loads the latch on select rise.
// Edges in the first cycle after reset release are ignored.
module swctl_shift_latch #(
    parameter int NUM_SW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_rise,
    input  logic              cs_low,
    input  logic              din,
    output logic [NUM_SW-1:0] shift_q,
    output logic              dout_q,
    output logic [NUM_SW-1:0] latch_q
);

    localparam int MSB = NUM_SW - 1;

    logic armed_q;
    logic shift_en;
    logic echo_en;
    logic load_en;

    // Arm the port one cycle after reset release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign shift_en = armed_q & cs_low & sclk_rise;
    assign echo_en  = armed_q & cs_low & sclk_fall;
    assign load_en  = armed_q & cs_rise;

    // Serial shift toward the MSB
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        shift_q <= '0;
        else if (shift_en) shift_q <= {shift_q[MSB-1:0], din};
    end

    // Echo of the MSB, updated on falling serial clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dout_q <= 1'b0;
        else if (echo_en) dout_q <= shift_q[MSB];
    end

    // Switch latch, loaded on select release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       latch_q <= '0;
        else if (load_en) latch_q <= shift_q;
    end

endmodule

// File: rtl/swctl_serial_top.sv
`timescale 1ns/1ps
// Serial-loaded latched switch controller top level. Synchronizes the
// reset release and the three port pins to clk, then drives the shift and
// latch core. Assumes clk is at least four times the serial clock rate.
module swctl_serial_top
    import swctl_pkg::*;
#(
    parameter int NUM_SW      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              din_i,
    output logic              dout_o,
    output logic [NUM_SW-1:0] sw_en_o
);

    logic        rst_sync_n;
    pins_t       pins_raw;
    pins_t       pins_lvl;
    pins_t       pins_rise;
    pins_t       pins_fall;
    logic        sclk_rise;
    logic        sclk_fall;
    logic        cs_rise;
    logic        cs_low;
    logic        din_lvl;
    logic [NUM_SW-1:0] shift_q;

    swctl_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
        .clk     (clk),
        .rst_n_i (rst_n),
        .rst_n_o (rst_sync_n)
    );

    assign pins_raw = '{din: din_i, cs_n: cs_n_i, sclk: sclk_i};

    swctl_pin_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) pin_sync_i (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .pin_i  (pins_raw),
        .lvl_o  (pins_lvl),
        .rise_o (pins_rise),
        .fall_o (pins_fall)
    );

    assign sclk_rise = pins_rise.sclk;
    assign sclk_fall = pins_fall.sclk;
    assign cs_rise   = pins_rise.cs_n;
    assign cs_low    = ~pins_lvl.cs_n;
    assign din_lvl   = pins_lvl.din;

    swctl_shift_latch #(.NUM_SW(NUM_SW)) core_i (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_rise   (cs_rise),
        .cs_low    (cs_low),
        .din       (din_lvl),
        .shift_q   (shift_q),
        .dout_q    (dout_o),
        .latch_q   (sw_en_o)
    );

endmodule

// File: rtl/swctl_serial_chk.sv
`timescale 1ns/1ps
// Checker for swctl_serial_top, bound into it below. It watches the
// synchronized edge flags, the shift register and the outputs.
module swctl_serial_chk #(
    parameter int NUM_SW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_sync_n,
    input logic              sclk_rise,
    input logic              sclk_fall,
    input logic              cs_rise,
    input logic              cs_low,
    input logic              din_lvl,
    input logic [NUM_SW-1:0] shift_q,
    input logic              dout_o,
    input logic [NUM_SW-1:0] sw_en_o
);

    // R1: outputs are cleared whenever reset is held
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            assert_reset_clear_R1: assert (sw_en_o == '0 && dout_o == 1'b0)
                else $error("reset did not clear outputs");
        end
    end

    // R2: a qualified rising clock shifts the data bit in at bit 0
    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (sclk_rise && cs_low) |=>
            shift_q == {$past(shift_q[NUM_SW-2:0]), $past(din_lvl)});

    // R3: the latch changes only right after a select rise
    assert_latch_only_on_cs_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !$stable(sw_en_o) |-> $past(cs_rise));

    // R3: the latch takes the register value present at the select rise
    assert_latch_value_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
        cs_rise |=> sw_en_o == $past(shift_q));

    // R5: the echo changes only after a qualified falling clock
    assert_echo_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !$stable(dout_o) |-> $past(sclk_fall && cs_low));

    // R7: with the select high the register holds
    assert_hold_when_deselected_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !cs_low |=> $stable(shift_q));

endmodule

bind swctl_serial_top swctl_serial_chk #(.NUM_SW(NUM_SW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .cs_rise    (cs_rise),
    .cs_low     (cs_low),
    .din_lvl    (din_lvl),
    .shift_q    (shift_q),
    .dout_o     (dout_o),
    .sw_en_o    (sw_en_o)
);

// File: tb/swctl_serial_top_tb_top.sv
`timescale 1ns/1ps
// Bench for swctl_serial_top: directed corner cases plus seeded random
// frames, checked against a bench-side model of the requirements.
module swctl_serial_top_tb_top;

    localparam int NSW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic din = 1'b0;
    logic dout;
    logic [NSW-1:0] sw_en;

    int tests = 0;
    int fails = 0;

    logic [NSW-1:0] m_sr = '0;
    logic [NSW-1:0] m_latch = '0;
    logic           m_dout = 1'b0;

    always #2 clk = ~clk;

    swctl_serial_top #(.NUM_SW(NSW)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk),
        .cs_n_i  (cs_n),
        .din_i   (din),
        .dout_o  (dout),
        .sw_en_o (sw_en)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ph();
        return 4 + int'($urandom_range(2, 0));
    endfunction

    // Send n bits of data, MSB first; end_high leaves the clock high at select rise
    task automatic send(input logic [15:0] data, input int n, input bit end_high);
        cs_n = 1'b0;
        wait_clk(ph());
        for (int i = n - 1; i >= 0; i--) begin
            din = data[i];
            wait_clk(ph());
            sclk = 1'b1;
            m_sr = {m_sr[NSW-2:0], data[i]};
            wait_clk(ph());
            chk("R4", sw_en, m_latch);
            if (!(end_high && i == 0)) begin
                sclk = 1'b0;
                m_dout = m_sr[NSW-1];
                wait_clk(ph());
                chk("R5", dout, m_dout);
            end
        end
        cs_n = 1'b1;
        m_latch = m_sr;
        wait_clk(ph());
        chk("R3", sw_en, m_latch);
        if (sclk) begin
            sclk = 1'b0;
            wait_clk(ph());
        end
        chk("R7", dout, m_dout);
    endtask

    // Toggle clock and data with the select high; nothing may change
    task automatic noise(input int k);
        for (int i = 0; i < k; i++) begin
            din = 1'($urandom_range(1, 0));
            sclk = ~sclk;
            wait_clk(ph());
        end
        sclk = 1'b0;
        wait_clk(ph());
        chk("R7", dout, m_dout);
        chk("R7", sw_en, m_latch);
    endtask

    initial begin
        logic [NSW-1:0] keep;
        void'($urandom(32'd5150));
        wait_clk(5);
        chk("R1", sw_en, 0);
        chk("R1", dout, 0);
        rst_n = 1'b1;
        wait_clk(6);

        // R2: bit mapping, first bit lands in bit 7
        send(16'h0081, 8, 1'b0);
        chk("R2", sw_en, 8'h81);
        send(16'h0001, 8, 1'b0);
        chk("R2", sw_en, 8'h01);

        // R8: select rises while the serial clock is high
        send(16'h0055, 8, 1'b1);
        chk("R8", sw_en, 8'h55);

        // R6: long frame keeps the last eight, short frame shifts partially
        send(16'h0ABC, 12, 1'b0);
        chk("R6", sw_en, 8'hBC);
        send(16'h0005, 3, 1'b0);
        chk("R6", sw_en, 8'hE5);

        // R7: activity with the select high, then an empty frame reloads
        keep = m_latch;
        noise(9);
        send(16'h0000, 0, 1'b0);
        chk("R7", sw_en, keep);

        // Random frames
        for (int f = 0; f < 60; f++) begin
            send(16'($urandom_range(16'hFFFF, 0)), int'($urandom_range(12, 1)),
                 1'($urandom_range(1, 0)));
            if (f % 10 == 0) noise(4);
        end

        // R1 and R9: reset mid-operation clears the outputs and the register
        send(16'h00FF, 8, 1'b0);
        chk("R2", sw_en, 8'hFF);
        #1 rst_n = 1'b0;
        #1;
        chk("R1", sw_en, 0);
        chk("R1", dout, 0);
        m_sr = '0;
        m_latch = '0;
        m_dout = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(6);
        send(16'h0000, 0, 1'b0);
        chk("R9", sw_en, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule